// File: doc/BRIEF.md
# Quadrature Position Decoder with Wrapping Counter

This block turns the two phase signals of an incremental encoder into a position value, a direction indication and a sticky wrap event. The phase pins are asynchronous. Each one passes through a synchronizer and then through an agreement filter clocked by the system clock. The filter removes short glitches and adds a fixed, known latency.

The filtered phase pair is decoded in x4 fashion: every edge of either phase moves the position by one count. The count goes up when phase A leads and down when phase B leads. The position is a modulo counter bounded by a programmable maximum. Stepping up from the maximum returns it to zero, and stepping down from zero reloads the maximum. Every such wrap raises an event flag. The flag stays high until the host pulses the clear input.

Top module: `qdec_wrap_top`

## Requirements
- R1: A phase pulse that lasts fewer than 3 clock samples after synchronization is discarded. The position and the direction do not change.
- R2: A single phase change applied between clock edges reaches the position output on the 7th rising clock edge after it is applied. That is 2 synchronizer stages, 3 filter samples, 1 filtered-output register and 1 position register.
- R3: The phase pair {A,B} runs through the sequence 00, 01, 11, 10, 00. Each step in that order increments the position by one.
- R4: Each step in the opposite order (00, 10, 11, 01, 00) decrements the position by one.
- R5: A transition in which A and B both change at once is illegal. It does not change the position or the direction.
- R6: On a forward step, when the position equals the maximum input, the position loads 0 instead of incrementing. This is a rollover.
- R7: On a reverse step, when the position is 0, the position loads the maximum input. This is an underflow.
- R8: Every rollover or underflow sets the wrap flag on the same clock edge that updates the position. The flag then stays at 1 until a cycle with the clear input at 1 and no wrap.
- R9: When the clear input and a wrap occur in the same cycle, the flag ends the cycle at 1.
- R10: After reset, the position is 0, the wrap flag is 0 and the direction output is 1 (up).
- R11: The direction output is 1 after a forward step and 0 after a reverse step.
- R12: With a maximum of 0, the position stays at 0, and every valid step counts as a wrap and sets the flag.
- R13: While the maximum input is held constant, the position never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Raw encoder phase A, asynchronous |
| phase_b | input | 1 | Raw encoder phase B, asynchronous |
| max_count | input | 16 | Upper bound of the position counter |
| wrap_clr | input | 1 | Clears the wrap flag when high |
| position | output | 16 | Current position, 0 to max_count |
| dir_up | output | 1 | 1 after a forward step, 0 after a reverse step |
| wrap_flag | output | 1 | Sticky rollover/underflow event |

## Verification
On every cycle, the bound checker checks four things: that the position moves only by one count or by a legal wrap, that the flag goes up whenever the position crosses between maximum and zero, that the flag stays set until a clear, and that the direction changes only together with a position change. The reset values are also checked. Several behaviours appear only in the bench scenarios. These are the exact seven-edge latency, glitch rejection, the handling of illegal double transitions, the clear-versus-wrap collision in a single cycle, and the zero-maximum case. The bench drives these in directed sequences, then runs a long seeded random walk of forward and reverse steps with random clears, compared against a bench model.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Map the phase pair {A,B} to its position in the forward cycle 00,01,11,10.
  function automatic logic [1:0] phase_to_idx(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  // Classify a move between two cycle positions.
  function automatic step_e classify(input logic [1:0] prev_idx, input logic [1:0] cur_idx);
    logic [1:0] delta;
    delta = cur_idx - prev_idx;
    case (delta)
      2'd1:    return STEP_UP;
      2'd3:    return STEP_DOWN;
      2'd2:    return STEP_BAD;
      default: return STEP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/qdec_in_filter.sv
module qdec_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic level
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;
  localparam int FILT_MSB = FILT_LEN - 1;

  logic [SYNC_MSB:0] sync_q;
  logic [FILT_MSB:0] hist_q;
  logic              all_high;
  logic              all_low;

  // Synchronizer chain: the first stage sees the asynchronous pin.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pin_raw;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  // Sample history of the synchronized level, newest in bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q[0] <= sync_q[SYNC_MSB];
      for (int i = 1; i < FILT_LEN; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  assign all_high = &hist_q;
  assign all_low  = ~(|hist_q);

  // The filtered level moves only once every stored sample agrees.
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else if (all_high) begin
      level <= 1'b1;
    end else if (all_low) begin
      level <= 1'b0;
    end
  end

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  pair,
  output step_e       step
);

  logic [1:0] prev_pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pair_q <= 2'b00;
    end else begin
      prev_pair_q <= pair;
    end
  end

  always_comb begin
    step = classify(phase_to_idx(prev_pair_q), phase_to_idx(pair));
  end

endmodule

// File: rtl/qdec_position.sv
module qdec_position
  import qdec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  input  logic [POS_W-1:0] max_count,
  input  logic             wrap_clr,
  output logic [POS_W-1:0] position,
  output logic             dir_up,
  output logic             wrap_flag
);

  localparam logic [POS_W-1:0] ZERO = '0;
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  logic [POS_W-1:0] pos_next;
  logic             dir_next;
  logic             wrap_now;

  always_comb begin
    pos_next = position;
    dir_next = dir_up;
    wrap_now = 1'b0;
    case (step)
      STEP_UP: begin
        dir_next = 1'b1;
        if (position >= max_count) begin
          pos_next = ZERO;
          wrap_now = 1'b1;
        end else begin
          pos_next = position + ONE;
        end
      end
      STEP_DOWN: begin
        dir_next = 1'b0;
        if (position == ZERO) begin
          pos_next = max_count;
          wrap_now = 1'b1;
        end else if (position > max_count) begin
          pos_next = max_count;
        end else begin
          pos_next = position - ONE;
        end
      end
      default: begin
        pos_next = position;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      position  <= ZERO;
      dir_up    <= 1'b1;
      wrap_flag <= 1'b0;
    end else begin
      position  <= pos_next;
      dir_up    <= dir_next;
      wrap_flag <= wrap_now | (wrap_flag & ~wrap_clr);
    end
  end

endmodule

// File: rtl/qdec_wrap_top.sv
module qdec_wrap_top
  import qdec_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [POS_W-1:0] max_count,
  input  logic             wrap_clr,
  output logic [POS_W-1:0] position,
  output logic             dir_up,
  output logic             wrap_flag
);

  localparam int PHASES = 2;

  logic [PHASES-1:0] raw_pair;
  logic [PHASES-1:0] clean_pair;
  step_e             step;

  assign raw_pair = {phase_a, phase_b};

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    qdec_in_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin_raw(raw_pair[g]),
      .level  (clean_pair[g])
    );
  end

  qdec_step_decode u_dec (
    .clk (clk),
    .rst (rst),
    .pair(clean_pair),
    .step(step)
  );

  qdec_position #(.POS_W(POS_W)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .max_count(max_count),
    .wrap_clr (wrap_clr),
    .position (position),
    .dir_up   (dir_up),
    .wrap_flag(wrap_flag)
  );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] max_count,
  input logic             wrap_clr,
  input logic [POS_W-1:0] position,
  input logic             dir_up,
  input logic             wrap_flag
);

  assert_reset_state_R10: assert property (@(posedge clk)
    $past(rst) |-> (position == '0 && !wrap_flag && dir_up));

  assert_step_size_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && position != $past(position)) |->
      (position == $past(position) + 1'b1 || position == $past(position) - 1'b1 ||
       position == '0 || position == $past(max_count)));

  assert_rollover_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dir_up && $past(max_count) != '0 &&
     $past(position) == $past(max_count) && position == '0) |-> wrap_flag);

  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !dir_up && $past(max_count) != '0 &&
     $past(position) == '0 && position == $past(max_count)) |-> wrap_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrap_flag) && !$past(wrap_clr)) |-> wrap_flag);

  assert_dir_with_move_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dir_up != $past(dir_up) && $past(max_count) != '0) |->
      position != $past(position));

endmodule

bind qdec_wrap_top qdec_checker #(.POS_W(POS_W)) u_qdec_chk (
  .clk      (clk),
  .rst      (rst),
  .max_count(max_count),
  .wrap_clr (wrap_clr),
  .position (position),
  .dir_up   (dir_up),
  .wrap_flag(wrap_flag)
);

// File: tb/test_qdec_wrap_top.sv
`timescale 1ns/1ps
module test_qdec_wrap_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_a = 1'b0;
  logic        phase_b = 1'b0;
  logic [15:0] max_count = 16'd5;
  logic        wrap_clr = 1'b0;
  logic [15:0] position;
  logic        dir_up;
  logic        wrap_flag;

  int errs = 0;
  int checks = 0;

  logic [1:0]  cur_idx = 2'd0;
  logic [15:0] exp_pos = 16'd0;
  logic        exp_dir = 1'b1;
  logic        exp_flag = 1'b0;

  always #10 clk = ~clk;

  qdec_wrap_top i_qdec_wrap_top (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .max_count(max_count), .wrap_clr(wrap_clr),
    .position(position), .dir_up(dir_up), .wrap_flag(wrap_flag)
  );

  function automatic logic [1:0] idx_to_pair(input logic [1:0] idx);
    case (idx)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [15:0] model_up(input logic [15:0] p, input logic [15:0] m);
    return (p >= m) ? 16'd0 : p + 16'd1;
  endfunction

  function automatic logic [15:0] model_down(input logic [15:0] p, input logic [15:0] m);
    return (p == 16'd0) ? m : p - 16'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " position"}, 32'(position), 32'(exp_pos));
    check({req, " dir"}, 32'(dir_up), 32'(exp_dir));
    check({req, " flag"}, 32'(wrap_flag), 32'(exp_flag));
  endtask

  task automatic drive_idx(input logic [1:0] idx);
    logic [1:0] p;
    p = idx_to_pair(idx);
    phase_a = p[1];
    phase_b = p[0];
  endtask

  // One quadrature step, applied at a falling edge, settled for 12 cycles.
  task automatic do_step(input logic up);
    @(negedge clk);
    cur_idx = up ? cur_idx + 2'd1 : cur_idx - 2'd1;
    drive_idx(cur_idx);
    if (up) begin
      if (exp_pos >= max_count) exp_flag = 1'b1;
      exp_pos = model_up(exp_pos, max_count);
    end else begin
      if (exp_pos == 16'd0) exp_flag = 1'b1;
      exp_pos = model_down(exp_pos, max_count);
    end
    exp_dir = up;
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    wrap_clr = 1'b1;
    @(negedge clk);
    wrap_clr = 1'b0;
    exp_flag = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] hold_pos;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R10 reset");

    // R2: exact latency, forward step 00 -> 01
    @(negedge clk);
    cur_idx = 2'd1;
    drive_idx(cur_idx);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R2 before 7th edge", 32'(position), 32'd0);
    @(negedge clk);
    check("R2 at 7th edge", 32'(position), 32'd1);
    exp_pos = 16'd1;
    repeat (8) @(negedge clk);

    // R3 forward counting up to max, then R6 rollover with R8 flag
    for (int i = 0; i < 4; i++) begin
      do_step(1'b1);
      check_all("R3 forward");
    end
    check("R13 at max", 32'(position), 32'd5);
    do_step(1'b1);
    check_all("R6 rollover");
    check("R8 flag set", 32'(wrap_flag), 32'd1);
    repeat (5) @(negedge clk);
    check("R8 flag sticky", 32'(wrap_flag), 32'd1);
    pulse_clear();
    check("R8 flag cleared", 32'(wrap_flag), 32'd0);

    // R4 reverse and R7 underflow, R11 direction
    do_step(1'b0);
    check_all("R7 underflow");
    check("R11 dir down", 32'(dir_up), 32'd0);
    do_step(1'b0);
    check_all("R4 reverse");
    pulse_clear();

    // R1 glitch of two samples on A
    hold_pos = position;
    @(negedge clk);
    phase_a = ~phase_a;
    repeat (2) @(negedge clk);
    phase_a = ~phase_a;
    repeat (12) @(negedge clk);
    check("R1 glitch position", 32'(position), 32'(hold_pos));
    check("R1 glitch dir", 32'(dir_up), 32'd0);

    // R5 both phases change together
    @(negedge clk);
    cur_idx = cur_idx + 2'd2;
    drive_idx(cur_idx);
    repeat (12) @(negedge clk);
    check_all("R5 illegal double change");

    // R9 clear in the same cycle as a rollover
    while (exp_pos != max_count) do_step(1'b1);
    pulse_clear();
    @(negedge clk);
    cur_idx = cur_idx + 2'd1;
    drive_idx(cur_idx);
    repeat (6) @(negedge clk);
    wrap_clr = 1'b1;
    @(negedge clk);
    wrap_clr = 1'b0;
    exp_pos = 16'd0;
    exp_dir = 1'b1;
    exp_flag = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R9 wrap beats clear");
    pulse_clear();

    // R12 zero maximum
    max_count = 16'd0;
    do_step(1'b1);
    check_all("R12 zero max up");
    pulse_clear();
    do_step(1'b0);
    check_all("R12 zero max down");
    pulse_clear();

    // R7 with full-width maximum
    max_count = 16'hFFFF;
    do_step(1'b0);
    check_all("R7 full-width underflow");
    do_step(1'b1);
    check_all("R6 full-width rollover");
    pulse_clear();

    // Random walk with small maximum
    max_count = 16'd6;
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      do_step(1'($urandom % 2));
      check_all("R3/R4 random step");
      if (position > max_count) check("R13 bound", 32'(position), 32'(max_count));
      if (($urandom % 8) == 0) begin
        pulse_clear();
        check("R8 random clear", 32'(wrap_flag), 32'd0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule